// File: doc/BRIEF.md
# Instruction Fetch and Next-PC Unit

This block sits at the front of a single-cycle processor. It holds the program counter and reads the instruction word at that address from a small instruction store. It also works out the address to fetch on the next clock edge. Each cycle the PC either moves on to the next sequential word or jumps to a PC-relative branch target. A one-bit select from the decode and control logic makes that choice. The branch condition is evaluated outside this block. The unit only acts on the select it is given.

The branch target is the sequential address plus the 16-bit offset field, sign-extended and scaled by four. All address arithmetic wraps modulo 2^32. The instruction store is a read-only word array indexed by the low word-address bits of the PC. Its contents come from a fixed formula, so a bench can predict any fetched word from the address alone.

Top module: `fetch_npc_unit`

## Requirements
- R1: While `rst_n` is low the PC reads 0x00000000, regardless of `br_take` and `br_offset`, and the first edge after release advances from 0.
- R2: On a rising clock edge with `br_take` = 0, the PC becomes the previous PC plus 4.
- R3: On a rising clock edge with `br_take` = 1 and a non-negative `br_offset`, the PC becomes the previous PC + 4 + `br_offset` × 4.
- R4: A `br_offset` with bit 15 set is treated as a negative two's-complement value, so the target lies below PC + 4. For example, 0xFFFF gives a target equal to the current PC.
- R5: `instr` is combinational from the current PC. With k = PC[IMEM_AW+1:2], bits [15:0] hold k and bits [31:16] hold k XOR 0xC0DE.
- R6: PC arithmetic wraps modulo 2^32 on both the sequential and the branch path. For example, 0xFFFFFFFC plus 4 gives 0, and 0 with offset 0xFFFE gives 0xFFFFFFFC.
- R7: While `br_take` = 0, the value of `br_offset` has no effect on the next PC.
- R8: PC bits [1:0] are always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the PC updates on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| br_take | input | 1 | 1 selects the branch target, 0 selects the sequential address |
| br_offset | input | 16 | Signed word offset of the branch |
| pc | output | 32 | Current program counter |
| instr | output | 32 | Instruction word fetched at `pc` |

## Verification
Two functions can act in the same cycle: adding the offset and wrapping past the top of the address space. The bench provokes this by taking a negative-offset branch straight out of reset, which lands on 0xFFFFFFFC. A sequential step from there must then return to 0. A full sweep of all 65536 offsets, with the select toggled by a bit pattern, repeatedly carries the PC across the 2^32 boundary in both directions. Every resulting PC and fetched word is compared against the bench's own modular arithmetic and store formula.

// File: rtl/fetch_npc_pkg.sv
package fetch_npc_pkg;
  localparam int XLEN  = 32;
  localparam int OFF_W = 16;
  localparam logic [15:0] ROM_TAG = 16'hC0DE;

  function automatic logic [XLEN-1:0] seq_addr(input logic [XLEN-1:0] cur);
    return cur + XLEN'(4);
  endfunction

  function automatic logic [XLEN-1:0] scale_off(input logic [OFF_W-1:0] off);
    return {{(XLEN-OFF_W-2){off[OFF_W-1]}}, off, 2'b00};
  endfunction

  function automatic logic [XLEN-1:0] rel_addr(input logic [XLEN-1:0] cur,
                                               input logic [OFF_W-1:0] off);
    return seq_addr(cur) + scale_off(off);
  endfunction

  function automatic logic [31:0] rom_word(input logic [15:0] k);
    return {k ^ ROM_TAG, k};
  endfunction
endpackage

// File: rtl/fnu_pc_reg.sv
module fnu_pc_reg #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= d;
  end
endmodule

// File: rtl/fnu_next_pc.sv
module fnu_next_pc
  import fetch_npc_pkg::*;
(
  input  logic [XLEN-1:0]  cur_pc,
  input  logic             take,
  input  logic [OFF_W-1:0] off,
  output logic [XLEN-1:0]  seq_pc,
  output logic [XLEN-1:0]  br_pc,
  output logic [XLEN-1:0]  npc
);
  always_comb begin
    seq_pc = seq_addr(cur_pc);
    br_pc  = rel_addr(cur_pc, off);
    npc    = take ? br_pc : seq_pc;
  end
endmodule

// File: rtl/fnu_imem.sv
module fnu_imem
  import fetch_npc_pkg::*;
#(
  parameter int AW = 6
) (
  input  logic [AW-1:0] word_idx,
  output logic [31:0]   data
);
  localparam int DEPTH = 1 << AW;

  logic [31:0] store [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_word
    assign store[g] = rom_word(16'(g));
  end

  assign data = store[word_idx];
endmodule

// File: rtl/fetch_npc_unit.sv
module fetch_npc_unit
  import fetch_npc_pkg::*;
#(
  parameter int IMEM_AW = 6
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        br_take,
  input  logic [15:0] br_offset,
  output logic [31:0] pc,
  output logic [31:0] instr
);
  localparam int IDX_LO = 2;
  localparam int IDX_HI = IMEM_AW + 1;

  logic [XLEN-1:0]    pc_q;
  logic [XLEN-1:0]    seq_pc;
  logic [XLEN-1:0]    br_pc;
  logic [XLEN-1:0]    npc;
  logic [IMEM_AW-1:0] fetch_idx;

  fnu_pc_reg #(.W(XLEN)) u_pc (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (npc),
    .q     (pc_q)
  );

  fnu_next_pc u_npc (
    .cur_pc (pc_q),
    .take   (br_take),
    .off    (br_offset),
    .seq_pc (seq_pc),
    .br_pc  (br_pc),
    .npc    (npc)
  );

  assign fetch_idx = pc_q[IDX_HI:IDX_LO];

  fnu_imem #(.AW(IMEM_AW)) u_imem (
    .word_idx (fetch_idx),
    .data     (instr)
  );

  assign pc = pc_q;
endmodule

// File: rtl/fetch_npc_chk.sv
module fetch_npc_chk #(
  parameter int IMEM_AW = 6
) (
  input logic        clk,
  input logic        rst_n,
  input logic        take,
  input logic [15:0] off,
  input logic [31:0] pc,
  input logic [31:0] instr,
  input logic [31:0] seq_pc,
  input logic [31:0] br_pc
);
  logic [31:0] off_bytes;
  logic [15:0] idx16;
  assign off_bytes = 32'($signed(off)) << 2;
  assign idx16     = 16'(pc[IMEM_AW+1:2]);

  AST_RESET_PC: assert property (@(posedge clk)
    !rst_n |=> pc == 32'h0); // R1

  AST_SEQ_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !take |=> pc == $past(pc) + 32'd4); // R2

  AST_BRANCH_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> pc == $past(pc) + 32'd4 + $past(off_bytes)); // R3

  AST_ROUTE_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> pc == ($past(take) ? $past(br_pc) : $past(seq_pc))); // R7

  AST_FETCH_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    instr == {idx16 ^ 16'hC0DE, idx16}); // R5

  AST_WORD_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    pc[1:0] == 2'b00); // R8
endmodule

bind fetch_npc_unit fetch_npc_chk #(.IMEM_AW(IMEM_AW)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .take   (br_take),
  .off    (br_offset),
  .pc     (pc),
  .instr  (instr),
  .seq_pc (seq_pc),
  .br_pc  (br_pc)
);

// File: tb/sim_fetch_npc_unit.sv
module sim_fetch_npc_unit;
  localparam int AW = 6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        take = 1'b0;
  logic [15:0] off = 16'h0;
  logic [31:0] pc;
  logic [31:0] instr;

  int          n_chk = 0;
  int          n_bad = 0;
  logic [31:0] model_pc = 32'h0;

  always #10 clk = ~clk;

  fetch_npc_unit #(.IMEM_AW(AW)) u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .br_take   (take),
    .br_offset (off),
    .pc        (pc),
    .instr     (instr)
  );

  function automatic logic [31:0] word_at(input logic [31:0] a);
    int k;
    k = int'((a / 4) % (1 << AW));
    return {16'(k) ^ 16'hC0DE, 16'(k)};
  endfunction

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] want);
    n_chk++;
    if (got !== want) begin
      n_bad++;
      $display("FAIL %s got %h expected %h", tag, got, want);
    end
  endtask

  task automatic cyc(input bit s, input logic [15:0] v, input string tag);
    take = s;
    off  = v;
    @(posedge clk);
    if (s) model_pc = model_pc + 32'd4 + 32'(4 * int'($signed(v)));
    else   model_pc = model_pc + 32'd4;
    @(negedge clk);
    check({tag, " pc"}, pc, model_pc);
    check({tag, " R5 instr"}, instr, word_at(model_pc));
    check("R8 align", {30'd0, pc[1:0]}, 32'd0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    take = 1'b1;
    off  = 16'h0040;
    repeat (2) @(negedge clk);
    check("R1 reset pc", pc, 32'h0);
    check("R1 reset R5 instr", instr, word_at(32'h0));
    rst_n = 1'b1;
    model_pc = 32'h0;

    cyc(1'b0, 16'h1234, "R2 R7 seq");
    cyc(1'b1, 16'h0003, "R3 fwd");
    cyc(1'b1, 16'hFFFF, "R4 self");
    cyc(1'b1, 16'h8000, "R4 R6 far back");
    cyc(1'b0, 16'h7FFF, "R2 R7 seq");

    rst_n = 1'b0;
    #1;
    check("R1 async clear", pc, 32'h0);
    @(negedge clk);
    check("R1 held", pc, 32'h0);
    rst_n = 1'b1;
    model_pc = 32'h0;

    cyc(1'b1, 16'hFFFE, "R4 R6 wrap down");
    cyc(1'b0, 16'hABCD, "R6 wrap up");
    cyc(1'b1, 16'h7FFF, "R3 max fwd");

    for (int i = 0; i < 65536; i++) begin
      logic [15:0] v;
      bit          s;
      v = 16'(i);
      s = v[0] ^ v[3] ^ v[9];
      cyc(s, v, s ? (v[15] ? "R4 sweep" : "R3 sweep") : "R7 sweep");
    end

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule